// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a one-way word buffer between two unrelated clock domains. A producer writes 18-bit words on its own clock and a consumer reads them in the same order on a second clock. Each side has an enable, and a transfer takes place only on a rising edge of that side's clock. The read data leaves through a register.

The buffer holds 256 words. It drives four active-low status flags. Full and almost-full belong to the write clock. Empty and almost-empty belong to the read clock. Each threshold flag compares against an offset that the host can load. The almost-full offset is loaded from the write domain and the almost-empty offset from the read domain. Both offsets come out of reset at 8.

Pointers cross between the domains as Gray code through two-flop synchronizers. A flag therefore asserts on the very edge that causes it, and releases only after the opposite side's pointer has crossed over. One active-low reset clears both domains and must be applied before the first write.

Top module: `xdom_fifo`

## Requirements
- R1: While reset is asserted and right after it, empty_n and aempty_n are 0, and full_n and afull_n are 1.
- R2: Words come out on rd_data in exactly the order they were accepted, all 18 bits intact, including when both sides run at the same time.
- R3: A write is taken only on a wr_clk edge where wr_en is 1 and full_n is 1. A write attempted while full_n is 0 stores nothing.
- R4: A read is taken only on an rd_clk edge where rd_en is 1 and empty_n is 1. A read attempted while empty_n is 0 moves nothing, and empty_n stays 0.
- R5: full_n is 0 exactly when 256 words are stored, as seen from the write side. The stored count never goes above 256.
- R6: afull_n is 0 when the free space is at or below the almost-full offset (default 8). With 247 words stored it is 1, with 248 it is 0, and it returns to 1 once reads have drained the buffer and crossed over.
- R7: aempty_n is 0 when the stored count is at or below the almost-empty offset (default 8). It is 0 at 5 and at 8 words and 1 at 9 words. Whenever empty_n is 0, aempty_n is 0 too.
- R8: A pulse on af_load captures af_value as the almost-full offset, and a pulse on ae_load captures ae_value as the almost-empty offset. The thresholds then follow the new values. With an almost-empty offset of 3, aempty_n is 0 at 3 words and 1 at 4. With an almost-full offset of 20, afull_n is 1 at 235 words and 0 at 236.
- R9: full_n goes to 0 on the write edge that stores the 256th word. empty_n goes to 0 on the read edge that removes the last word.
- R10: A reset in the middle of operation discards the contents and returns the flags to their R1 values. The first word written after it is the first word read.
- R11: rd_data changes only on an rd_clk edge that takes a read, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write request, sampled on wr_clk |
| wr_data | input | 18 | Word to store |
| af_load | input | 1 | Load af_value as the almost-full offset (wr_clk) |
| af_value | input | 9 | New almost-full offset |
| full_n | output | 1 | Low when the buffer is full |
| afull_n | output | 1 | Low when free space is at or below the almost-full offset |
| rd_en | input | 1 | Read request, sampled on rd_clk |
| rd_data | output | 18 | Registered output word |
| ae_load | input | 1 | Load ae_value as the almost-empty offset (rd_clk) |
| ae_value | input | 9 | New almost-empty offset |
| empty_n | output | 1 | Low when the buffer is empty |
| aempty_n | output | 1 | Low when the stored count is at or below the almost-empty offset |

## Verification
A short burst into an empty buffer, read back in one run, separates a correct order from a lost or repeated word. It also shows whether empty asserts on the last read edge. A full 256-word fill followed by one extra write separates a correct overflow block from a pointer that wraps, because a stray word would survive the drain. Simultaneous streams on the two unrelated clocks test the Gray crossing under pointer motion. Loading new offsets and stepping the count one word across each threshold tells an at-or-below comparison from a strictly-below one.

// File: rtl/xdom_fifo_pkg.sv
`timescale 1ns/1ps
package xdom_fifo_pkg;
  // Which end of the buffer a control instance serves.
  typedef enum logic {
    SIDE_PUSH = 1'b0,
    SIDE_POP  = 1'b1
  } side_e;

  localparam int unsigned DEF_DATA_W = 18;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_OFS    = 8;
  localparam int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/xdom_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a Gray-coded pointer.
module xdom_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[s] <= '0;
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/xdom_ram.sv
`timescale 1ns/1ps
// Storage array: write port on one clock, registered read port on the other.
module xdom_ram #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_clk,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_go) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)     rd_word <= '0;
    else if (rd_go) rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/xdom_side.sv
`timescale 1ns/1ps
// Pointer, offset and flag logic for one end of the buffer.
// Push end: room = free space, flags are full / almost-full.
// Pop end:  room = stored words, flags are empty / almost-empty.
module xdom_side
  import xdom_fifo_pkg::*;
#(
  parameter side_e       SIDE    = SIDE_PUSH,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned OFS_RST = DEF_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              ofs_load,
  input  logic [ADDR_W:0]   ofs_value,
  input  logic [ADDR_W:0]   far_gray,
  output logic              go,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W:0]   ptr_gray,
  output logic              flag_n,
  output logic              thr_n
);
  localparam int unsigned      CNT_W    = ADDR_W + 1;
  localparam int unsigned      DEPTH    = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] OFS_C    = CNT_W'(OFS_RST);
  localparam logic [CNT_W-1:0] RST_ROOM = (SIDE == SIDE_PUSH) ? DEPTH_C : '0;

  function automatic logic [CNT_W-1:0] to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] from_gray(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Words held, seen from this end.
  function automatic logic [CNT_W-1:0] level(input logic [CNT_W-1:0] own,
                                             input logic [CNT_W-1:0] far);
    return (SIDE == SIDE_PUSH) ? (own - far) : (far - own);
  endfunction

  // Quantity whose exhaustion raises this end's flags.
  function automatic logic [CNT_W-1:0] room(input logic [CNT_W-1:0] lvl);
    return (SIDE == SIDE_PUSH) ? (DEPTH_C - lvl) : lvl;
  endfunction

  logic [CNT_W-1:0] ptr_q, ptr_nxt, far_bin, lvl_cur, lvl_nxt, room_nxt, ofs_q;
  logic             flag_n_q, thr_n_q;
  logic             blocked;

  assign far_bin  = from_gray(far_gray);
  assign go       = req & flag_n_q;
  assign blocked  = req & ~flag_n_q;
  assign ptr_nxt  = ptr_q + CNT_W'(go);
  assign lvl_cur  = level(ptr_q, far_bin);
  assign lvl_nxt  = level(ptr_nxt, far_bin);
  assign room_nxt = room(lvl_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      ptr_gray <= '0;
      ofs_q    <= OFS_C;
      flag_n_q <= (RST_ROOM != '0);
      thr_n_q  <= (RST_ROOM > OFS_C);
    end else begin
      ptr_q    <= ptr_nxt;
      ptr_gray <= to_gray(ptr_nxt);
      if (ofs_load) ofs_q <= ofs_value;
      flag_n_q <= (room_nxt != '0);
      thr_n_q  <= (room_nxt > ofs_q);
    end
  end

  assign addr   = ptr_q[ADDR_W-1:0];
  assign flag_n = flag_n_q;
  assign thr_n  = thr_n_q;

  // R3 (push end) and R4 (pop end): a refused request leaves the pointer alone.
  a_r3_r4_blocked_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> ptr_q == $past(ptr_q));

  // R5: the level seen from either end never exceeds the depth or wraps negative.
  a_r5_level_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_cur <= DEPTH_C);

  // R7: an exhausted end always shows its threshold flag as well.
  a_r7_flag_implies_thr: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_n_q |-> !thr_n_q);

  // R2: the crossing pointer changes by at most one bit per edge.
  a_r2_gray_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ptr_gray ^ $past(ptr_gray)) <= 1);
endmodule

// File: rtl/xdom_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO with active-low full/empty and programmable threshold flags.
module xdom_fifo
  import xdom_fifo_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC,
  parameter int unsigned OFS_RST     = DEF_OFS
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              af_load,
  input  logic [ADDR_W:0]   af_value,
  output logic              full_n,
  output logic              afull_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ae_load,
  input  logic [ADDR_W:0]   ae_value,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int unsigned CNT_W = ADDR_W + 1;

  logic              wr_go, rd_go;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [CNT_W-1:0]  wr_gray, rd_gray, wr_gray_at_rd, rd_gray_at_wr;

  xdom_side #(.SIDE(SIDE_PUSH), .ADDR_W(ADDR_W), .OFS_RST(OFS_RST)) u_push (
    .clk(wr_clk), .rst_n(rst_n), .req(wr_en),
    .ofs_load(af_load), .ofs_value(af_value), .far_gray(rd_gray_at_wr),
    .go(wr_go), .addr(wr_addr), .ptr_gray(wr_gray),
    .flag_n(full_n), .thr_n(afull_n)
  );

  xdom_side #(.SIDE(SIDE_POP), .ADDR_W(ADDR_W), .OFS_RST(OFS_RST)) u_pop (
    .clk(rd_clk), .rst_n(rst_n), .req(rd_en),
    .ofs_load(ae_load), .ofs_value(ae_value), .far_gray(wr_gray_at_rd),
    .go(rd_go), .addr(rd_addr), .ptr_gray(rd_gray),
    .flag_n(empty_n), .thr_n(aempty_n)
  );

  xdom_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_at_rd)
  );

  xdom_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_at_wr)
  );

  xdom_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .wr_go(wr_go), .wr_addr(wr_addr), .wr_word(wr_data),
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_go(rd_go), .rd_addr(rd_addr),
    .rd_word(rd_data)
  );

  // R11: without an accepted read the output word holds.
  a_r11_data_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(rd_en && empty_n) |=> $stable(rd_data));

  // R9: empty on the pop side means no read can be granted.
  a_r9_no_read_when_empty: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !rd_go);
endmodule

// File: tb/test_xdom_fifo.sv
`timescale 1ns/1ps
module test_xdom_fifo;
  localparam int DW = 18;
  localparam int AW = 8;

  logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0, af_load = 1'b0, rd_en = 1'b0, ae_load = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW:0]   af_value = '0, ae_value = '0;
  logic          full_n, afull_n, empty_n, aempty_n;
  logic [DW-1:0] rd_data;

  int       n_chk = 0, n_fail = 0;
  bit       done = 0, armed = 0;
  logic [DW-1:0] exp_q[$];

  always #10 wr_clk = ~wr_clk;   // 50 MHz write clock
  always #14 rd_clk = ~rd_clk;   // unrelated read clock

  xdom_fifo i_xdom_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .af_load(af_load), .af_value(af_value),
    .full_n(full_n), .afull_n(afull_n),
    .rd_en(rd_en), .rd_data(rd_data), .ae_load(ae_load), .ae_value(ae_value),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: the word is expected only if full_n allows it on the coming edge.
  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wr_clk); #1;
    if (full_n) exp_q.push_back(d);
    wr_en = 1'b1; wr_data = d;
  endtask

  task automatic wr_idle();
    @(negedge wr_clk); #1; wr_en = 1'b0;
  endtask

  task automatic wr_burst(input int n, input int base);
    for (int i = 0; i < n; i++) wr_word(DW'(base + i));
    wr_idle();
  endtask

  task automatic rd_n(input int n);
    repeat (n) begin @(negedge rd_clk); #1; rd_en = 1'b1; end
    @(negedge rd_clk); #1; rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic load_af(input int v);
    @(negedge wr_clk); #1; af_load = 1'b1; af_value = (AW+1)'(v);
    @(negedge wr_clk); #1; af_load = 1'b0;
  endtask

  task automatic load_ae(input int v);
    @(negedge rd_clk); #1; ae_load = 1'b1; ae_value = (AW+1)'(v);
    @(negedge rd_clk); #1; ae_load = 1'b0;
  endtask

  task automatic check_reset_flags(input string tag);
    check_eq({tag, " empty_n"},  empty_n,  0);
    check_eq({tag, " aempty_n"}, aempty_n, 0);
    check_eq({tag, " full_n"},   full_n,   1);
    check_eq({tag, " afull_n"},  afull_n,  1);
  endtask

  // Monitor: arm for the coming read edge, compare one cycle later.
  initial begin
    forever begin
      @(negedge rd_clk);
      if (armed) begin
        if (exp_q.size() == 0) check_eq("R2 word with nothing expected", rd_data, -1);
        else check_eq("R2 read order", rd_data, exp_q.pop_front());
      end
      armed = 0;
      #2;
      armed = rst_n && rd_en && empty_n;
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    // R1: reset state
    repeat (3) @(negedge wr_clk);
    check_reset_flags("R1 in reset");
    #1 rst_n = 1'b1;
    settle();
    check_reset_flags("R1 after reset");

    // R7: default almost-empty threshold, stepping 5 -> 8 -> 9 words
    wr_burst(5, 18'h00010);
    settle();
    check_eq("R2 empty_n after writes", empty_n, 1);
    check_eq("R7 aempty_n at 5", aempty_n, 0);
    wr_burst(3, 18'h00015);
    settle();
    check_eq("R7 aempty_n at 8", aempty_n, 0);
    wr_burst(1, 18'h3FFFF);
    settle();
    check_eq("R7 aempty_n at 9", aempty_n, 1);

    // R2/R9: drain in one run, empty on the last read edge
    rd_n(9);
    check_eq("R9 empty_n on last read", empty_n, 0);
    check_eq("R2 queue drained", exp_q.size(), 0);

    // R4/R11: reads while empty are ignored
    held = rd_data;
    rd_n(3);
    check_eq("R11 rd_data held on empty reads", rd_data, held);
    check_eq("R4 empty_n stays low", empty_n, 0);
    wr_burst(1, 18'h2BCDE);
    settle();
    rd_n(1);
    check_eq("R4 next word after empty reads", rd_data, 18'h2BCDE);

    // R6/R5/R9/R3: fill with the default almost-full threshold
    settle();
    wr_burst(247, 18'h01000);
    check_eq("R6 afull_n at 247", afull_n, 1);
    wr_burst(1, 18'h01000 + 247);
    check_eq("R6 afull_n at 248", afull_n, 0);
    check_eq("R5 full_n at 248", full_n, 1);
    wr_burst(7, 18'h01000 + 248);
    check_eq("R5 full_n at 255", full_n, 1);
    wr_burst(1, 18'h01000 + 255);
    check_eq("R9 full_n on 256th write", full_n, 0);
    wr_burst(1, 18'h3A5A5);
    check_eq("R3 full_n after refused write", full_n, 0);
    check_eq("R3 refused word not queued", exp_q.size(), 256);
    rd_n(257);
    settle();
    check_eq("R3 nothing left after drain", empty_n, 0);
    check_eq("R2 fill drained", exp_q.size(), 0);
    check_eq("R6 afull_n released", afull_n, 1);
    check_eq("R5 full_n released", full_n, 1);

    // R2: both sides running together
    fork
      wr_burst(40, 18'h20000);
      rd_n(60);
    join
    for (int k = 0; k < 20 && exp_q.size() != 0; k++) begin
      settle();
      rd_n(4);
    end
    settle();
    check_eq("R2 concurrent stream drained", exp_q.size(), 0);
    check_eq("R2 empty after stream", empty_n, 0);

    // R8: loaded offsets
    load_ae(3);
    load_af(20);
    wr_burst(3, 18'h03000);
    settle();
    check_eq("R8 aempty_n at 3 with offset 3", aempty_n, 0);
    wr_burst(1, 18'h03003);
    settle();
    check_eq("R8 aempty_n at 4 with offset 3", aempty_n, 1);
    wr_burst(231, 18'h03004);
    check_eq("R8 afull_n at 235 with offset 20", afull_n, 1);
    wr_burst(1, 18'h030EB);
    check_eq("R8 afull_n at 236 with offset 20", afull_n, 0);
    rd_n(240);
    settle();
    check_eq("R8 drained", exp_q.size(), 0);

    // R10: reset in mid-operation
    wr_burst(10, 18'h04000);
    settle();
    check_eq("R10 data present before reset", empty_n, 1);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    exp_q.delete();
    check_reset_flags("R10 in reset");
    #1 rst_n = 1'b1;
    settle();
    check_reset_flags("R10 after reset");
    wr_burst(1, 18'h15A5A);
    settle();
    check_eq("R10 empty_n after one write", empty_n, 1);
    rd_n(1);
    check_eq("R10 first word after reset", rd_data, 18'h15A5A);
    check_eq("R7 aempty restored to default", aempty_n, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule